// File: doc/BRIEF.md
# ADC Host Bring-Up and Readout Sequencer

This block sits on the host side of a multichannel delta-sigma converter that talks in frames of 16-bit words over SPI. It drives a word-transfer port toward an SPI master and takes the converter from power-up to continuous readout without software help. First it clears the power-up lock, then it issues a soft reset. It keeps sending null frames until the converter reports ready. It then writes a burst of configuration registers, switches the channels on, wakes the converter and locks its registers. After that it reads one status-plus-data frame each time an interval expires.

The converter answers a command in the frame after the one that carried it. For this reason the ready word is looked for in the first word received during each poll frame. The block always clocks every frame out in full and pads unused words with zeros, because the converter acts on a reset only when the frame completes. A poll budget bounds the wait for ready. When the budget runs out, the block stops and raises an error flag. A frame holds one status word plus one word per channel. The configuration burst must fit in one frame: it needs one command word plus one word per two registers.

Top module: `adc_boot_seq`

## Requirements
- R1: After reset, `ready`, `error` and `wx_start` are low. The first frame carries 0x0655 (unlock) in word 0. The second frame carries 0x0011 (soft reset) in word 0.
- R2: Every frame has exactly NCH+1 word transfers. `wx_last` is high only for the last word. Every word after word 0 of a non-configuration frame is 0x0000.
- R3: After the reset frame, the block sends null frames (word 0 = 0x0000). It leaves this loop after the first poll frame whose received word 0 equals 0xFF04.
- R4: If `cfg_poll_max` poll frames (0 is treated as 1) all end without 0xFF04, `error` goes high and stays high, and no further transfer starts.
- R5: The frame after a successful poll is a burst write. Word 0 is 011 followed by the 5-bit start address and the 8-bit register count minus one. The default is 0x6B04. The next words pack two register bytes each, first register in the high byte, zero-padded: E83E, 02A0, 0F00, 0000.
- R6: After the burst, three single-command frames follow in this order: 0x4F0F (channel enable), 0x0033 (wake), 0x0555 (lock).
- R7: After the lock frame, `ready` is high. Null read frames then repeat, and each one starts `cfg_interval` idle cycles after the previous frame ends (0 is treated as 1).
- R8: At the end of each run frame, `data_valid` pulses for one cycle. `status_word` shows received word 0 and `ch_data[16*i +: 16]` shows received word i+1. The first run frame's status is the acknowledgement of the lock command.
- R9: Only one word transfer is outstanding at a time. `wx_start` is a one-cycle pulse, and `wx_data` holds steady until `wx_done`.
- R10: Once high, `ready` and `error` each stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_poll_max | input | POLL_W | Poll frames allowed before error |
| cfg_interval | input | IVL_W | Idle cycles between run frames |
| wx_start | output | 1 | One-cycle request to shift one word |
| wx_data | output | 16 | Word to transmit |
| wx_last | output | 1 | Current word closes the frame |
| wx_done | input | 1 | Word transfer finished |
| wx_rdata | input | 16 | Word received during the transfer |
| ready | output | 1 | Converter running, readout active |
| error | output | 1 | Ready poll timed out |
| data_valid | output | 1 | New status and channel words |
| status_word | output | 16 | Received word 0 of last run frame |
| ch_data | output | 16*NCH | Received channel words, channel 0 lowest |

## Verification
The bench sweeps how many null frames the converter model needs before it reports ready, from zero up to and past the poll budget. This separates the success path from an off-by-one at the timeout edge, including a budget of a single frame. A model that honours the lock and ignores the unlock shows that a reset sent into a locked converter ends in the timeout. Each success case uses a different read interval, so gap-length errors cannot hide behind one fixed value. The captured status and channel words are compared with the exact words the model sent in that frame.

// File: rtl/adc_boot_pkg.sv
// Shared constants and state types for the converter bring-up sequencer.
// Assumes 16-bit words with no error-coding bits.
package adc_boot_pkg;
    localparam int          WORD_W     = 16;
    localparam logic [15:0] CMD_NULL   = 16'h0000;
    localparam logic [15:0] CMD_RESET  = 16'h0011;
    localparam logic [15:0] CMD_UNLOCK = 16'h0655;
    localparam logic [15:0] CMD_WAKE   = 16'h0033;
    localparam logic [15:0] CMD_LOCK   = 16'h0555;
    localparam logic [15:0] RESP_READY = 16'hFF04;

    typedef enum logic [3:0] {
        ST_UNLOCK, ST_RESET, ST_POLL, ST_CFG, ST_ENABLE,
        ST_WAKE, ST_LOCK, ST_RUN, ST_FAULT
    } seq_state_t;

    typedef enum logic [1:0] {FE_IDLE, FE_ISSUE, FE_WAIT} fe_state_t;

    // Single-register write: 010 aaaaa dddddddd
    function automatic logic [15:0] wreg_one(input logic [4:0] addr, input logic [7:0] data);
        return {3'b010, addr, data};
    endfunction

    // Burst write header: 011 aaaaa (count-1)
    function automatic logic [15:0] wreg_burst(input logic [4:0] addr, input logic [7:0] cnt_m1);
        return {3'b011, addr, cnt_m1};
    endfunction
endpackage

// File: rtl/adc_frame_engine.sv
// Frame engine: on a go pulse, runs FW back-to-back word transfers over
// the start/done port. The caller supplies the word to send for each index.
// Received words are kept for the whole frame, and a one-cycle pulse marks
// the frame's end.
// Assumes the SPI master keeps chip select asserted until the word flagged last.
module adc_frame_engine
    import adc_boot_pkg::*;
#(
    parameter int FW    = 5,
    localparam int IDX_W = $clog2(FW)
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic [WORD_W-1:0]    tx_word,
    output logic [IDX_W-1:0]     idx,
    output logic                 wx_start,
    output logic [WORD_W-1:0]    wx_data,
    output logic                 wx_last,
    input  logic                 wx_done,
    input  logic [WORD_W-1:0]    wx_rdata,
    output logic [FW*WORD_W-1:0] rx_words,
    output logic                 frame_done,
    output logic                 busy
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FW - 1);

    fe_state_t st;

    // Word-level handshake, receive storage and the end-of-frame pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= FE_IDLE;
            idx        <= '0;
            frame_done <= 1'b0;
            rx_words   <= '0;
        end else begin
            frame_done <= 1'b0;
            case (st)
                FE_IDLE: begin
                    if (go) begin
                        st  <= FE_ISSUE;
                        idx <= '0;
                    end
                end
                FE_ISSUE: st <= FE_WAIT;
                FE_WAIT: begin
                    if (wx_done) begin
                        rx_words[idx*WORD_W +: WORD_W] <= wx_rdata;
                        if (idx == LAST_IDX) begin
                            st         <= FE_IDLE;
                            frame_done <= 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= FE_ISSUE;
                        end
                    end
                end
                default: st <= FE_IDLE;
            endcase
        end
    end

    // Port drive: the request pulse, the word held through the transfer, the last flag
    always_comb begin
        busy     = (st != FE_IDLE);
        wx_start = (st == FE_ISSUE);
        wx_data  = busy ? tx_word : '0;
        wx_last  = busy && (idx == LAST_IDX);
    end
endmodule

// File: rtl/adc_ivl_timer.sv
// Interval timer: counts enabled cycles and pulses tick for one cycle when
// limit cycles have passed. It clears whenever the enable drops.
// A limit of zero acts as one.
module adc_ivl_timer #(
    parameter int IVL_W = 16
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [IVL_W-1:0] limit,
    output logic             tick
);
    logic [IVL_W-1:0] cnt;
    logic [IVL_W-1:0] lim_eff;

    // Effective limit and expiry detect
    always_comb begin
        lim_eff = (limit == '0) ? IVL_W'(1) : limit;
        tick    = en && (cnt == lim_eff - 1'b1);
    end

    // Cycle counter, cleared while disabled or on expiry
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) cnt <= '0;
        else                       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/adc_boot_seq.sv
// Converter bring-up sequencer (top). Step order: unlock, soft reset,
// ready poll, register burst, channel enable, wake, lock, timed readout.
// It judges the poll on received word 0, which carries the answer to the
// previous frame's command.
// Assumes 1 + ceil(CFG_NREG/2) <= NCH + 1 so the burst fits in one frame.
module adc_boot_seq
    import adc_boot_pkg::*;
#(
    parameter int                  NCH        = 4,
    parameter int                  POLL_W     = 8,
    parameter int                  IVL_W      = 16,
    parameter logic [4:0]          CFG_ADDR   = 5'h0B,
    parameter int                  CFG_NREG   = 5,
    parameter logic [CFG_NREG*8-1:0] CFG_DATA = 40'hE83E02A00F,
    parameter logic [4:0]          EN_ADDR    = 5'h0F,
    parameter logic [7:0]          EN_MASK    = 8'h0F
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [POLL_W-1:0]     cfg_poll_max,
    input  logic [IVL_W-1:0]      cfg_interval,
    output logic                  wx_start,
    output logic [15:0]           wx_data,
    output logic                  wx_last,
    input  logic                  wx_done,
    input  logic [15:0]           wx_rdata,
    output logic                  ready,
    output logic                  error,
    output logic                  data_valid,
    output logic [15:0]           status_word,
    output logic [NCH*16-1:0]     ch_data
);
    localparam int FW    = NCH + 1;
    localparam int IDX_W = $clog2(FW);

    seq_state_t           st;
    logic                 in_frame;
    logic                 launch;
    logic                 tick;
    logic                 fe_busy;
    logic                 frame_done;
    logic [IDX_W-1:0]     idx;
    logic [WORD_W-1:0]    tx_word;
    logic [FW*WORD_W-1:0] rx_words;
    logic [POLL_W-1:0]    poll_cnt;
    logic [POLL_W:0]      poll_next;
    logic [POLL_W:0]      poll_lim;
    logic [WORD_W-1:0]    burst_word [FW];

    // Burst frame words computed from the parameters: header, then byte pairs
    generate
        for (genvar w = 0; w < FW; w++) begin : g_burst
            if (w == 0) begin : g_hdr
                assign burst_word[w] = wreg_burst(CFG_ADDR, 8'(CFG_NREG - 1));
            end else begin : g_pair
                localparam int B0 = 2 * (w - 1);
                localparam int B1 = B0 + 1;
                logic [7:0] hi, lo;
                if (B0 < CFG_NREG) begin : g_hi
                    assign hi = CFG_DATA[(CFG_NREG-1-B0)*8 +: 8];
                end else begin : g_hi0
                    assign hi = 8'h00;
                end
                if (B1 < CFG_NREG) begin : g_lo
                    assign lo = CFG_DATA[(CFG_NREG-1-B1)*8 +: 8];
                end else begin : g_lo0
                    assign lo = 8'h00;
                end
                assign burst_word[w] = {hi, lo};
            end
        end
    endgenerate

    // Word to send for the current step and word index; unused words pad to zero
    always_comb begin
        tx_word = CMD_NULL;
        case (st)
            ST_UNLOCK: if (idx == '0) tx_word = CMD_UNLOCK;
            ST_RESET:  if (idx == '0) tx_word = CMD_RESET;
            ST_CFG:    tx_word = burst_word[idx];
            ST_ENABLE: if (idx == '0) tx_word = wreg_one(EN_ADDR, EN_MASK);
            ST_WAKE:   if (idx == '0) tx_word = CMD_WAKE;
            ST_LOCK:   if (idx == '0) tx_word = CMD_LOCK;
            default:   tx_word = CMD_NULL;
        endcase
    end

    // Frame launch: command steps go at once, readout waits for the timer
    always_comb begin
        launch = 1'b0;
        if (!in_frame) begin
            case (st)
                ST_RUN, ST_FAULT: launch = (st == ST_RUN) && tick;
                default:          launch = 1'b1;
            endcase
        end
        poll_next = {1'b0, poll_cnt} + 1'b1;
        poll_lim  = (cfg_poll_max == '0) ? (POLL_W+1)'(1) : {1'b0, cfg_poll_max};
    end

    adc_frame_engine #(.FW(FW)) u_fe (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (launch),
        .tx_word    (tx_word),
        .idx        (idx),
        .wx_start   (wx_start),
        .wx_data    (wx_data),
        .wx_last    (wx_last),
        .wx_done    (wx_done),
        .wx_rdata   (wx_rdata),
        .rx_words   (rx_words),
        .frame_done (frame_done),
        .busy       (fe_busy)
    );

    adc_ivl_timer #(.IVL_W(IVL_W)) u_ivl (
        .clk   (clk),
        .rst_n (rst_n),
        .en    ((st == ST_RUN) && !in_frame && !fe_busy),
        .limit (cfg_interval),
        .tick  (tick)
    );

    // Step sequencing, poll budget and readout capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_UNLOCK;
            in_frame    <= 1'b0;
            poll_cnt    <= '0;
            data_valid  <= 1'b0;
            status_word <= '0;
            ch_data     <= '0;
        end else begin
            data_valid <= 1'b0;
            if (launch) in_frame <= 1'b1;
            if (frame_done) begin
                in_frame <= 1'b0;
                case (st)
                    ST_UNLOCK: st <= ST_RESET;
                    ST_RESET: begin
                        st       <= ST_POLL;
                        poll_cnt <= '0;
                    end
                    ST_POLL: begin
                        if (rx_words[WORD_W-1:0] == RESP_READY) st <= ST_CFG;
                        else if (poll_next >= poll_lim)          st <= ST_FAULT;
                        else                                     poll_cnt <= poll_next[POLL_W-1:0];
                    end
                    ST_CFG:    st <= ST_ENABLE;
                    ST_ENABLE: st <= ST_WAKE;
                    ST_WAKE:   st <= ST_LOCK;
                    ST_LOCK:   st <= ST_RUN;
                    ST_RUN: begin
                        status_word <= rx_words[WORD_W-1:0];
                        ch_data     <= rx_words[FW*WORD_W-1:WORD_W];
                        data_valid  <= 1'b1;
                    end
                    default: st <= ST_FAULT;
                endcase
            end
        end
    end

    // Status flags decoded from the step
    always_comb begin
        ready = (st == ST_RUN);
        error = (st == ST_FAULT);
    end
endmodule

// File: rtl/adc_boot_seq_chk.sv
// Checker for adc_boot_seq: port-level rules for the transfer handshake and the flags.
// It keeps its own copy of transfer occupancy.
module adc_boot_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wx_start,
    input logic [15:0] wx_data,
    input logic        wx_done,
    input logic        ready,
    input logic        error,
    input logic        data_valid
);
    logic busy_q;

    // Track one outstanding transfer from request to completion
    always_ff @(posedge clk) begin
        if (!rst_n)        busy_q <= 1'b0;
        else if (wx_start) busy_q <= 1'b1;
        else if (wx_done)  busy_q <= 1'b0;
    end

    // R9
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wx_start |=> !wx_start);
    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !wx_start);
    // R9
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !wx_done) |=> $stable(wx_data));
    // R10
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
    // R10
    error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);
    // R4
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !wx_start);
    // R8
    valid_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> ready);
    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);
endmodule

bind adc_boot_seq adc_boot_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wx_start   (wx_start),
    .wx_data    (wx_data),
    .wx_done    (wx_done),
    .ready      (ready),
    .error      (error),
    .data_valid (data_valid)
);

// File: tb/sim_adc_boot_seq.sv
// Bench: a converter model with a lock and a one-frame-late answer. It
// sweeps the ready delay, the poll budget, the read interval and whether
// the unlock takes effect.
module sim_adc_boot_seq;
    localparam int NCH = 4;
    localparam int FW  = NCH + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [7:0]        poll_max = 8'd4;
    logic [15:0]       interval = 16'd1;
    logic              wx_done  = 1'b0;
    logic [15:0]       wx_rdata = 16'h0;
    wire               wx_start, wx_last, ready, error, data_valid;
    wire [15:0]        wx_data, status_word;
    wire [NCH*16-1:0]  ch_data;

    adc_boot_seq #(.NCH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_poll_max(poll_max), .cfg_interval(interval),
        .wx_start(wx_start), .wx_data(wx_data), .wx_last(wx_last),
        .wx_done(wx_done), .wx_rdata(wx_rdata), .ready(ready), .error(error),
        .data_valid(data_valid), .status_word(status_word), .ch_data(ch_data)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // converter model state
    int          boot_k = 0;
    bit          ign_unlock = 1'b0;
    bit          locked;
    int          boot_left;
    logic [15:0] resp;
    bit          pend;
    int          lat;
    logic [15:0] cur_tx;
    bit          cur_last;
    int          wcnt, nframes, nvalid, cyc, done_cyc;
    logic [15:0] ftx [FW];
    logic [15:0] last_rx [FW];
    logic [15:0] log0 [64];
    int          gap_log [64];
    logic [15:0] cfg_log [FW];
    bit          wc_bad, pad_bad;

    // Model: answers each word two cycles after the request, acts on commands at frame end
    always @(negedge clk) begin
        cyc++;
        wx_done = 1'b0;
        if (!rst_n) begin
            locked = 1'b1; boot_left = 0; resp = 16'h2210; pend = 1'b0;
            wcnt = 0; nframes = 0; nvalid = 0; done_cyc = 0;
            wc_bad = 1'b0; pad_bad = 1'b0;
            for (int i = 0; i < 64; i++) begin log0[i] = 16'hDEAD; gap_log[i] = -1; end
            for (int i = 0; i < FW; i++) begin cfg_log[i] = 16'hDEAD; last_rx[i] = 16'h0; end
        end else begin
            if (data_valid) begin
                // R8: captured words equal the words sent in that frame
                chk(status_word == last_rx[0], "R8", "status word", status_word, last_rx[0]);
                if (nvalid == 0)
                    chk(status_word == 16'h0555, "R8", "first run status", status_word, 16'h0555);
                for (int i = 0; i < NCH; i++)
                    chk(ch_data[16*i +: 16] == last_rx[i+1], "R8", "channel word",
                        ch_data[16*i +: 16], last_rx[i+1]);
                nvalid++;
            end
            if (wx_start) begin
                if (wcnt == 0 && nframes < 64) gap_log[nframes] = cyc - done_cyc;
                pend = 1'b1; lat = 2; cur_tx = wx_data; cur_last = wx_last;
            end else if (pend) begin
                lat--;
                if (lat == 0) begin
                    pend = 1'b0;
                    wx_done = 1'b1;
                    wx_rdata = (wcnt == 0) ? resp : {nframes[7:0], wcnt[7:0]};
                    if (wcnt < FW) begin ftx[wcnt] = cur_tx; last_rx[wcnt] = wx_rdata; end
                    if (cur_last != (wcnt == FW-1)) wc_bad = 1'b1;
                    if (cur_last || wcnt >= FW-1) begin
                        if (ftx[0] == 16'h6B04) begin
                            for (int i = 0; i < FW; i++) cfg_log[i] = ftx[i];
                        end else begin
                            for (int i = 1; i < FW; i++) if (ftx[i] != 16'h0) pad_bad = 1'b1;
                        end
                        if (nframes < 64) log0[nframes] = ftx[0];
                        case (ftx[0])
                            16'h0655: begin if (!ign_unlock) locked = 1'b0; resp = 16'h0655; end
                            16'h0011: begin
                                if (!locked) begin
                                    boot_left = boot_k;
                                    resp = (boot_k == 0) ? 16'hFF04 : 16'h2210;
                                end else resp = 16'h2210;
                            end
                            16'h0000: begin
                                if (boot_left > 0) begin
                                    boot_left--;
                                    resp = (boot_left == 0) ? 16'hFF04 : 16'h2210;
                                end else resp = 16'h2210;
                            end
                            default: resp = ftx[0];
                        endcase
                        nframes++;
                        done_cyc = cyc;
                        wcnt = 0;
                    end else wcnt++;
                end
            end
        end
    end

    task automatic run_case(input int k, input int pm, input int ivl, input bit ign);
        bit ok_path;
        int npoll, base;
        bit seq_ok, gap_ok;
        @(negedge clk); #1;
        rst_n = 1'b0; boot_k = k; ign_unlock = ign;
        poll_max = 8'(pm); interval = 16'(ivl);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(!ready && !error && !wx_start, "R1", "reset outputs", {ready, error, wx_start}, 0);
        #1 rst_n = 1'b1;
        for (int t = 0; t < 6000; t++) begin
            @(negedge clk);
            if (nvalid >= 3 || error) break;
        end
        repeat (60) @(negedge clk);
        ok_path = !ign && (k < pm);
        npoll = ok_path ? k + 1 : pm;
        chk(log0[0] == 16'h0655, "R1", "unlock frame", log0[0], 16'h0655);
        chk(log0[1] == 16'h0011, "R1", "reset frame", log0[1], 16'h0011);
        seq_ok = 1'b1;
        for (int i = 0; i < npoll; i++) if (log0[2+i] != 16'h0000) seq_ok = 1'b0;
        chk(seq_ok, "R3", "poll frames are null", seq_ok, 1);
        chk(!wc_bad, "R2", "word count and last flag", wc_bad, 0);
        chk(!pad_bad, "R2", "zero padding", pad_bad, 0);
        base = 2 + npoll;
        if (ok_path) begin
            chk(log0[base] == 16'h6B04, "R3", "burst follows ready poll", log0[base], 16'h6B04);
            chk(cfg_log[0] == 16'h6B04 && cfg_log[1] == 16'hE83E && cfg_log[2] == 16'h02A0,
                "R5", "burst words 0-2", {cfg_log[1], cfg_log[2]}, 32'hE83E02A0);
            chk(cfg_log[3] == 16'h0F00 && cfg_log[4] == 16'h0000, "R5", "burst words 3-4",
                {cfg_log[3], cfg_log[4]}, 32'h0F000000);
            chk(log0[base+1] == 16'h4F0F, "R6", "enable frame", log0[base+1], 16'h4F0F);
            chk(log0[base+2] == 16'h0033, "R6", "wake frame", log0[base+2], 16'h0033);
            chk(log0[base+3] == 16'h0555, "R6", "lock frame", log0[base+3], 16'h0555);
            chk(ready && !error, "R7", "ready flag", {ready, error}, 2'b10);
            chk(nframes - (base + 4) >= 3, "R7", "run frame count", nframes - (base + 4), 3);
            gap_ok = 1'b1;
            for (int f = base + 4; f < nframes && f < 64; f++) begin
                if (log0[f] != 16'h0000) gap_ok = 1'b0;
                if (gap_log[f] != ivl + 2) gap_ok = 1'b0;
            end
            chk(gap_ok, "R7", "run frame null and spacing", gap_log[base+4], ivl + 2);
            chk(nvalid >= 3, "R8", "readouts captured", nvalid, 3);
        end else begin
            chk(error && !ready, "R4", "timeout flag", {ready, error}, 2'b01);
            chk(nframes == base, "R4", "no frames after timeout", nframes, base);
            chk(nvalid == 0, "R10", "no readout after error", nvalid, 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // ready delay swept across the budget of 4, interval varied per case
        for (int k = 0; k <= 5; k++) run_case(k, 4, (k % 4) + 1, 1'b0);
        // a budget of one frame: exact edge on both sides
        run_case(0, 1, 3, 1'b0);
        run_case(1, 1, 3, 1'b0);
        // converter ignores the unlock, so the reset is lost and the poll times out
        run_case(0, 4, 2, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule